// File: doc/BRIEF.md
# Cartridge ROM Bank Mapper

This block sits on the read side of a cartridge slot that sees a 20-bit byte address and an 8-bit data path. The two top address bits pick one of four 256 KiB windows. The lowest window shows the ROM directly. The next window shows the ROM through a bank number and a scramble pattern. The two upper windows are handed to a pair of external chip-select ports. For ROM reads the block forms the final ROM index and can return the data byte with its bit order reversed. For the upper windows it forwards the strobes, the address and the write data to the selected port.

A separate register block supplies the configuration: an 8-bit bank number, an 8-bit scramble mode and a one-bit reverse flag. The ROM is a power-of-two array inside the block. Its contents are computed from the index, so the block elaborates without any file. Read data comes back one cycle after the read strobe, together with a valid pulse.

Top module: `cart_bank_mapper`

## Requirements
- R1: Address bits 19:18 select the window: 0 direct ROM, 1 banked ROM, 2 chip-select port 0, 3 chip-select port 1.
- R2: In window 0 the ROM index is address bits 17:0 truncated to ROM_AW bits, and the returned byte is the ROM byte at that index.
- R3: In window 1 the index is ((bank << 18) | addr[17:0]) XOR S, truncated to ROM_AW bits. S has bits 12:8 equal to mode[6:2], bit 7 equal to mode[1] OR mode[7], and all other bits zero.
- R4: In window 1, when mode[7] is 1 and address bit 0 is 0, index bits 12:2 are forced to zero after the XOR. When address bit 0 is 1, or mode[7] is 0, they are not forced.
- R5: When the reverse flag is 1 at the read strobe, a ROM byte from window 0 or 1 is returned with bit i moved to bit 7-i. Data from the chip-select ports is never reversed.
- R6: Windows 2 and 3 drive cs_addr with address bits 17:0 and cs_wdata with the bus write data. They raise only cs_rd[n] or cs_wr[n] for port n (n = 0 for window 2, n = 1 for window 3) in the same cycle as the bus strobe. A read returns that port's data.
- R7: rd_data and rd_valid update at the clock edge that samples bus_rd. rd_valid is high for exactly the cycles that follow a cycle with bus_rd high. rd_data holds its value while no read takes place.
- R8: A write or read to window 0 or 1 raises no chip-select strobe.
- R9: After reset rd_valid and rd_data are 0.
- R10: With bank, mode and reverse flag all zero, windows 0 and 1 return the same byte for the same low 18 address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 20 | Byte address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| cfg_bank | input | 8 | Bank number for window 1 |
| cfg_mode | input | 8 | Scramble mode for window 1 |
| cfg_rev | input | 1 | Reverse bit order of ROM data |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | Pulse one cycle after a read strobe |
| rom_addr | output | ROM_AW | Final ROM index for the present address |
| cs_addr | output | 18 | Address forwarded to the chip-select ports |
| cs_rd | output | 2 | Read strobe per chip-select port |
| cs_wr | output | 2 | Write strobe per chip-select port |
| cs_wdata | output | 8 | Write data forwarded to the ports |
| cs0_rdata | input | 8 | Read data from port 0 |
| cs1_rdata | input | 8 | Read data from port 1 |

## Verification
A wrong scramble term or a wrong mid-bit clear shows on rom_addr in the same cycle as the address. It also shows as a wrong rd_data one cycle later, so a single read exposes it. A bad window decode shows at once as a stray or missing chip-select strobe. A reversal fault or a latch fault in the read register shows on the first rd_data after the faulty read. The random mix changes bank, mode and flag on every access, so a fault that depends on the configuration appears within a few reads.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  localparam int WIN_AW  = 18;
  localparam int BANK_W  = 8;
  localparam int FULL_W  = WIN_AW + BANK_W;

  typedef enum logic [1:0] {
    WIN_ROM  = 2'd0,
    WIN_BANK = 2'd1,
    WIN_CS0  = 2'd2,
    WIN_CS1  = 2'd3
  } win_e;

  // XOR pattern derived from the mode byte
  function automatic logic [FULL_W-1:0] scramble_pat(input logic [7:0] mode);
    logic [FULL_W-1:0] p;
    p = '0;
    p[12:8] = mode[6:2];
    p[7]    = mode[1] | mode[7];
    return p;
  endfunction

  // banked index before the size mask
  function automatic logic [FULL_W-1:0] banked_index(
    input logic [WIN_AW-1:0] low,
    input logic [BANK_W-1:0] bank,
    input logic [7:0]        mode
  );
    logic [FULL_W-1:0] v;
    v = {bank, low};
    v = v ^ scramble_pat(mode);
    if (mode[7] && !low[0]) v[12:2] = '0;
    return v;
  endfunction

  function automatic logic [7:0] bit_rev(input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[7-i];
    return r;
  endfunction

  // ROM contents: fold of index bits plus a non-symmetric constant
  function automatic logic [7:0] rom_fill(input int unsigned idx, input int aw);
    logic [7:0] x;
    x = 8'h1D;
    for (int i = 0; i < aw; i++) x[i % 8] = x[i % 8] ^ idx[i];
    return x;
  endfunction

endpackage

// File: rtl/cart_map_addr.sv
module cart_map_addr
  import cart_map_pkg::*;
#(
  parameter int ROM_AW = 12
) (
  input  logic [19:0]       addr,
  input  logic [7:0]        bank,
  input  logic [7:0]        mode,
  output win_e              win,
  output logic [ROM_AW-1:0] idx,
  output logic              mid_clear
);
  logic [FULL_W-1:0] direct_full;
  logic [FULL_W-1:0] bank_full;

  assign win         = win_e'(addr[19:18]);
  assign mid_clear   = (win == WIN_BANK) && mode[7] && !addr[0];
  assign direct_full = {{BANK_W{1'b0}}, addr[WIN_AW-1:0]};
  assign bank_full   = banked_index(addr[WIN_AW-1:0], bank, mode);

  always_comb begin
    if (win == WIN_BANK) idx = bank_full[ROM_AW-1:0];
    else                 idx = direct_full[ROM_AW-1:0];
  end
endmodule

// File: rtl/cart_map_rom.sv
module cart_map_rom
  import cart_map_pkg::*;
#(
  parameter int ROM_AW = 12
) (
  input  logic [ROM_AW-1:0] idx,
  output logic [7:0]        q
);
  localparam int DEPTH = 1 << ROM_AW;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = rom_fill(i, ROM_AW);
  end

  assign q = mem[idx];
endmodule

// File: rtl/cart_map_cs.sv
module cart_map_cs
  import cart_map_pkg::*;
#(
  parameter int PORTS = 2
) (
  input  win_e             win,
  input  logic             rd,
  input  logic             wr,
  output logic [PORTS-1:0] cs_rd,
  output logic [PORTS-1:0] cs_wr
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic hit;
    assign hit      = (win == win_e'(p + 2));
    assign cs_rd[p] = hit && rd;
    assign cs_wr[p] = hit && wr;
  end
endmodule

// File: rtl/cart_map_rdpath.sv
module cart_map_rdpath
  import cart_map_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  win_e       win,
  input  logic       rd,
  input  logic       rev,
  input  logic [7:0] rom_q,
  input  logic [7:0] cs0_q,
  input  logic [7:0] cs1_q,
  output logic [7:0] data,
  output logic       valid
);
  logic [7:0] rom_ord;
  logic [7:0] sel;

  assign rom_ord = rev ? bit_rev(rom_q) : rom_q;

  always_comb begin
    unique case (win)
      WIN_CS0: sel = cs0_q;
      WIN_CS1: sel = cs1_q;
      default: sel = rom_ord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= rd;
      if (rd) data <= sel;
    end
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int ROM_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [19:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic [7:0]        cfg_bank,
  input  logic [7:0]        cfg_mode,
  input  logic              cfg_rev,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [17:0]       cs_addr,
  output logic [1:0]        cs_rd,
  output logic [1:0]        cs_wr,
  output logic [7:0]        cs_wdata,
  input  logic [7:0]        cs0_rdata,
  input  logic [7:0]        cs1_rdata
);
  win_e       win_sel;
  logic       mid_clear;
  logic [7:0] rom_q;

  cart_map_addr #(.ROM_AW(ROM_AW)) u_addr (
    .addr      (bus_addr),
    .bank      (cfg_bank),
    .mode      (cfg_mode),
    .win       (win_sel),
    .idx       (rom_addr),
    .mid_clear (mid_clear)
  );

  cart_map_rom #(.ROM_AW(ROM_AW)) u_rom (
    .idx (rom_addr),
    .q   (rom_q)
  );

  cart_map_cs #(.PORTS(2)) u_cs (
    .win   (win_sel),
    .rd    (bus_rd),
    .wr    (bus_wr),
    .cs_rd (cs_rd),
    .cs_wr (cs_wr)
  );

  cart_map_rdpath u_rd (
    .clk   (clk),
    .rst_n (rst_n),
    .win   (win_sel),
    .rd    (bus_rd),
    .rev   (cfg_rev),
    .rom_q (rom_q),
    .cs0_q (cs0_rdata),
    .cs1_q (cs1_rdata),
    .data  (rd_data),
    .valid (rd_valid)
  );

  assign cs_addr  = bus_addr[17:0];
  assign cs_wdata = bus_wdata;
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk #(
  parameter int ROM_AW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [19:0]       bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [7:0]        cfg_mode,
  input logic [7:0]        rd_data,
  input logic              rd_valid,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [1:0]        cs_rd,
  input logic [1:0]        cs_wr,
  input logic [7:0]        cs0_rdata,
  input logic [7:0]        cs1_rdata,
  input logic              mid_clear
);
  a_r7_valid_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> rd_valid);
  a_r7_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !rd_valid);
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(rd_data));
  a_r8_rom_win_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr[19] |-> (cs_rd == 2'b00 && cs_wr == 2'b00));
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_rd, cs_wr}) || (bus_rd && bus_wr));
  a_r6_cs0_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[19:18] == 2'd2) |=> rd_data == $past(cs0_rdata));
  a_r6_cs1_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[19:18] == 2'd3) |=> rd_data == $past(cs1_rdata));
  a_r4_mid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_clear && ROM_AW >= 13) |-> rom_addr[12 % ROM_AW:2 % ROM_AW] == '0);
  a_r4_only_even: assert property (@(posedge clk) disable iff (!rst_n)
    mid_clear |-> (!bus_addr[0] && cfg_mode[7]));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.ROM_AW(ROM_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .cfg_mode  (cfg_mode),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .rom_addr  (rom_addr),
  .cs_rd     (cs_rd),
  .cs_wr     (cs_wr),
  .cs0_rdata (cs0_rdata),
  .cs1_rdata (cs1_rdata),
  .mid_clear (mid_clear)
);

// File: tb/tb_cart_bank_mapper.sv
module tb_cart_bank_mapper;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [19:0]   bus_addr = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    cfg_bank = '0;
  logic [7:0]    cfg_mode = '0;
  logic          cfg_rev = 1'b0;
  logic [7:0]    rd_data;
  logic          rd_valid;
  logic [AW-1:0] rom_addr;
  logic [17:0]   cs_addr;
  logic [1:0]    cs_rd;
  logic [1:0]    cs_wr;
  logic [7:0]    cs_wdata;
  logic [7:0]    cs0_rdata;
  logic [7:0]    cs1_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign cs0_rdata = cs_addr[7:0] ^ 8'h66;
  assign cs1_rdata = ~cs_addr[15:8];

  cart_bank_mapper #(.ROM_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .cfg_bank(cfg_bank),
    .cfg_mode(cfg_mode), .cfg_rev(cfg_rev), .rd_data(rd_data),
    .rd_valid(rd_valid), .rom_addr(rom_addr), .cs_addr(cs_addr),
    .cs_rd(cs_rd), .cs_wr(cs_wr), .cs_wdata(cs_wdata),
    .cs0_rdata(cs0_rdata), .cs1_rdata(cs1_rdata)
  );

  function automatic int unsigned exp_index(int unsigned a, int unsigned bank, int unsigned mode);
    int unsigned v, m;
    if (((a >> 18) & 3) == 1) begin
      v = (a & 32'h3FFFF) | (bank << 18);
      v = v ^ (((mode & 32'h7E) << 6) | (mode & 32'h80));
      m = (1 << AW) - 1;
      if ((mode & 32'h80) != 0 && (a & 1) == 0) m = m & ~32'h1FFC;
      return v & m;
    end
    return a & 32'h3FFFF;
  endfunction

  function automatic logic [7:0] exp_rom(int unsigned idx);
    logic [7:0] x;
    x = 8'h1D;
    for (int i = 0; i < AW; i++) if ((idx >> i) & 1) x = x ^ (8'h01 << (i % 8));
    return x;
  endfunction

  function automatic logic [7:0] flip(logic [7:0] d);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) if (d[i]) r = r | (8'h80 >> i);
    return r;
  endfunction

  task automatic chk(bit ok, string tag, int unsigned act, int unsigned exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one read; returns data seen on the next cycle
  task automatic do_read(input logic [19:0] a, output logic [7:0] d);
    int unsigned w;
    logic [7:0] e;
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    w = (a >> 18) & 3;
    #1;
    if (w < 2) begin
      chk(rom_addr == exp_index(a, cfg_bank, cfg_mode), "R3 R4 rom_addr", rom_addr,
          exp_index(a, cfg_bank, cfg_mode));
      chk(cs_rd == 2'b00, "R8 no cs_rd on ROM read", cs_rd, 0);
      e = exp_rom(exp_index(a, cfg_bank, cfg_mode));
      if (cfg_rev) e = flip(e);
    end else begin
      chk(cs_rd == (w == 2 ? 2'b01 : 2'b10) && cs_addr == a[17:0], "R6 cs_rd/addr",
          {cs_rd, cs_addr}, {(w == 2 ? 2'b01 : 2'b10), a[17:0]});
      e = (w == 2) ? (a[7:0] ^ 8'h66) : ~a[15:8];
    end
    @(negedge clk);
    bus_rd = 1'b0;
    chk(rd_valid == 1'b1, "R7 rd_valid after read", rd_valid, 1);
    chk(rd_data == e, "R1 R2 R5 rd_data", rd_data, e);
    d = rd_data;
  endtask

  initial begin
    logic [7:0] d0, d1, hold;
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0 && rd_data == 8'h00, "R9 reset state", {rd_valid, rd_data}, 0);
    rst_n = 1'b1;

    // R10: zero config, windows 0 and 1 agree
    do_read(20'h01234, d0);
    do_read(20'h41234, d1);
    chk(d0 == d1, "R10 windows equal at zero config", d1, d0);
    do_read(20'h3FFFF, d0);
    do_read(20'h7FFFF, d1);
    chk(d0 == d1, "R10 windows equal top", d1, d0);

    // R4: mid clear on even address only
    cfg_mode = 8'h80;
    do_read(20'h5FFFE, d0);
    do_read(20'h5FFFF, d0);
    // R3: overlap on bit 7 of mode[1] and mode[7]
    cfg_mode = 8'h82;
    do_read(20'h40081, d0);
    cfg_mode = 8'h7E; cfg_bank = 8'h03;
    do_read(20'h40000, d0);

    // R5: reverse on ROM, not on chip-select data
    cfg_rev = 1'b1; cfg_mode = 8'h00; cfg_bank = 8'h00;
    do_read(20'h00001, d0);
    do_read(20'h80013, d0);
    cfg_rev = 1'b0;

    // R7: data holds without a read
    hold = rd_data;
    @(negedge clk);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R7 valid drops", rd_valid, 0);
    chk(rd_data == hold, "R7 data holds", rd_data, hold);

    // R8 / R6: writes
    @(negedge clk);
    bus_addr = 20'h00010; bus_wr = 1'b1; bus_wdata = 8'hA7; #1;
    chk(cs_wr == 2'b00, "R8 ROM write ignored", cs_wr, 0);
    @(negedge clk);
    bus_addr = 20'h40010; #1;
    chk(cs_wr == 2'b00, "R8 banked write ignored", cs_wr, 0);
    @(negedge clk);
    bus_addr = 20'hC0155; #1;
    chk(cs_wr == 2'b10 && cs_wdata == 8'hA7 && cs_addr == 18'h00155, "R6 cs1 write",
        {cs_wr, cs_wdata}, {2'b10, 8'hA7});
    @(negedge clk);
    bus_addr = 20'h80155; #1;
    chk(cs_wr == 2'b01, "R6 cs0 write", cs_wr, 1);
    @(negedge clk);
    bus_wr = 1'b0;
    chk(rd_valid == 1'b0, "R7 no valid on write", rd_valid, 0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      cfg_bank = 8'($urandom);
      cfg_mode = 8'($urandom);
      cfg_rev  = 1'($urandom);
      do_read(20'($urandom), d0);
    end
    done = 1'b1;
  end

  initial begin
    void'($urandom(32'd77));
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule